// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers interrupt sources in groups of 32 called banks and gives each bank one request line toward the processor. Each source is edge-captured into a pending bit that holds until software clears it. A bank drives its request line whenever some pending bit is also enabled. Alongside the line it gives the index of the highest-numbered pending and enabled source, so the service routine can go straight to the most urgent one without scanning.

Software reaches every bank through a flat 32-bit register bus. The bus has a write strobe, an address and write data, and the read data follows the address combinationally. Each bank owns five registers at offsets 0x00, 0x08, 0x10, 0x18 and 0x20 from its base. Bank b starts at byte address b*0x28. The pending bits clear when ones are written to them. A separate read-only view shows the pending bits gated by the enables. Software can also raise pending bits itself, and it can block chosen inputs from latching new edges.

Top module: `irqc_banked`

## Requirements
- R1: After reset every pending, enable and capture-block bit is 0, every request line and valid flag is low, every index is 0, and every register reads 0.
- R2: A 0-to-1 change on source N of bank B sets pending bit N of bank B at the next clock edge. That bit reads back at offsets 0x00 and 0x18. A source held high does not set the bit again after it is cleared.
- R3: Writing offset 0x00 clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a set (from an edge or a request write) and a clear hit the same pending bit in one cycle, the bit ends up set.
- R5: Offset 0x08 is the enable register. All 32 bits can be read and written.
- R6: Offset 0x10 reads pending AND enable. Writes to it change nothing.
- R7: Writing offset 0x18 sets each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R8: Offset 0x20 is a capture-block register (read/write). While its bit N is 1, edges on source N do not set the pending bit, but request writes at 0x18 still do.
- R9: Bank b decodes its registers at b*0x28 plus the offset. A write to one bank leaves the other banks unchanged.
- R10: Request line b is high exactly when bank b's pending-and-enabled vector is non-zero, and its valid flag equals the line.
- R11: The 5-bit index of bank b gives the highest set bit of its pending-and-enabled vector. It is 0 when that vector is zero.
- R12: An address whose low three bits are not zero, or one at or above NB*0x28, reads 0 and changes nothing when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NB*SRC_W | Source inputs, bank b in bits b*SRC_W and up |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | SRC_W | Write data |
| bus_rdata | output | SRC_W | Read data for bus_addr (combinational) |
| irq_o | output | NB | Request line per bank |
| prio_idx_o | output | NB*5 | Highest pending-and-enabled index per bank |
| prio_vld_o | output | NB | Index valid per bank |

## Verification
The bench builds the block with its defaults: five banks of 32 sources and an 8-bit address. With an 8-bit address the last bank ends at 199, so the unmapped range 200 to 255 and the misaligned addresses inside the banks can all be reached by writes and reads. With five banks, the decode stride is checked at several bases, including the last one. Random source toggles, mixed with writes to random registers, hit the same-cycle set-and-clear case and the full 0-to-31 index range.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_STRIDE = 40;
  localparam int unsigned OFF_RAW = 0;
  localparam int unsigned OFF_EN  = 8;
  localparam int unsigned OFF_OUT = 16;
  localparam int unsigned OFF_REQ = 24;
  localparam int unsigned OFF_BLK = 32;

  typedef enum logic [2:0] {
    SEL_RAW  = 3'd0,
    SEL_EN   = 3'd1,
    SEL_OUT  = 3'd2,
    SEL_REQ  = 3'd3,
    SEL_BLK  = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irqc_msb_enc.sv
module irqc_msb_enc #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  // Later (higher) bits overwrite earlier ones: highest index wins.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign vld_o = |vec_i;
endmodule

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
#(
  parameter int unsigned NB     = 5,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o [NB]
);
  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr_i);

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      sel_o[b] = SEL_NONE;
      if      (addr_ext == 32'(b * BANK_STRIDE + OFF_RAW)) sel_o[b] = SEL_RAW;
      else if (addr_ext == 32'(b * BANK_STRIDE + OFF_EN))  sel_o[b] = SEL_EN;
      else if (addr_ext == 32'(b * BANK_STRIDE + OFF_OUT)) sel_o[b] = SEL_OUT;
      else if (addr_ext == 32'(b * BANK_STRIDE + OFF_REQ)) sel_o[b] = SEL_REQ;
      else if (addr_ext == 32'(b * BANK_STRIDE + OFF_BLK)) sel_o[b] = SEL_BLK;
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned SRC_W = 32,
  localparam int unsigned IDX_W = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic [SRC_W-1:0] wdata_i,
  input  logic             wr_raw_i,
  input  logic             wr_en_i,
  input  logic             wr_req_i,
  input  logic             wr_blk_i,
  output logic [SRC_W-1:0] raw_o,
  output logic [SRC_W-1:0] en_o,
  output logic [SRC_W-1:0] blk_o,
  output logic [SRC_W-1:0] out_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  logic [SRC_W-1:0] prev_q, raw_q, en_q, blk_q;
  logic [SRC_W-1:0] rise, set_v, clr_v, raw_d;

  // next-state
  always_comb begin
    rise  = src_i & ~prev_q;
    set_v = (rise & ~blk_q) | (wr_req_i ? wdata_i : '0);
    clr_v = wr_raw_i ? wdata_i : '0;
    raw_d = (raw_q & ~clr_v) | set_v;   // set has priority over clear
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= src_i;
      raw_q  <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en_i) en_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= '0;
    else if (wr_blk_i) blk_q <= wdata_i;
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign blk_o = blk_q;
  assign out_o = raw_q & en_q;
  assign irq_o = |out_o;

  irqc_msb_enc #(.W(SRC_W), .IW(IDX_W)) i_enc (
    .vec_i (out_o),
    .idx_o (idx_o),
    .vld_o (vld_o)
  );
endmodule

// File: rtl/irqc_banked.sv
module irqc_banked
  import irqc_pkg::*;
#(
  parameter int unsigned NB     = 5,
  parameter int unsigned SRC_W  = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = $clog2(SRC_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NB*SRC_W-1:0] src_i,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [SRC_W-1:0]    bus_wdata,
  output logic [SRC_W-1:0]    bus_rdata,
  output logic [NB-1:0]       irq_o,
  output logic [NB*IDX_W-1:0] prio_idx_o,
  output logic [NB-1:0]       prio_vld_o
);
  reg_sel_e         sel [NB];
  logic [SRC_W-1:0] raw_w [NB];
  logic [SRC_W-1:0] en_w  [NB];
  logic [SRC_W-1:0] blk_w [NB];
  logic [SRC_W-1:0] out_w [NB];

  irqc_regdec #(.NB(NB), .ADDR_W(ADDR_W)) i_dec (
    .addr_i (bus_addr),
    .sel_o  (sel)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irqc_bank #(.SRC_W(SRC_W)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i[b*SRC_W +: SRC_W]),
      .wdata_i  (bus_wdata),
      .wr_raw_i (bus_we && (sel[b] == SEL_RAW)),
      .wr_en_i  (bus_we && (sel[b] == SEL_EN)),
      .wr_req_i (bus_we && (sel[b] == SEL_REQ)),
      .wr_blk_i (bus_we && (sel[b] == SEL_BLK)),
      .raw_o    (raw_w[b]),
      .en_o     (en_w[b]),
      .blk_o    (blk_w[b]),
      .out_o    (out_w[b]),
      .irq_o    (irq_o[b]),
      .idx_o    (prio_idx_o[b*IDX_W +: IDX_W]),
      .vld_o    (prio_vld_o[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      case (sel[b])
        SEL_RAW, SEL_REQ: bus_rdata = bus_rdata | raw_w[b];
        SEL_EN:           bus_rdata = bus_rdata | en_w[b];
        SEL_OUT:          bus_rdata = bus_rdata | out_w[b];
        SEL_BLK:          bus_rdata = bus_rdata | blk_w[b];
        default:          bus_rdata = bus_rdata;
      endcase
    end
  end
endmodule

// File: rtl/irqc_banked_chk.sv
module irqc_banked_chk #(
  parameter int unsigned NB    = 5,
  parameter int unsigned SRC_W = 32,
  localparam int unsigned IDX_W = $clog2(SRC_W)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NB*SRC_W-1:0] src_i,
  input logic                bus_we,
  input logic [NB-1:0]       irq_o,
  input logic [NB*IDX_W-1:0] prio_idx_o,
  input logic [NB-1:0]       prio_vld_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0) && (prio_vld_o == '0)); // R1

  for (genvar b = 0; b < NB; b++) begin : g_chk
    AST_VLD_TRACKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      prio_vld_o[b] == irq_o[b]); // R10

    AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !prio_vld_o[b] |-> (prio_idx_o[b*IDX_W +: IDX_W] == '0)); // R11

    AST_QUIET_IS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_we) && ($past(src_i[b*SRC_W +: SRC_W]) == '0))
        |-> ($stable(irq_o[b]) && $stable(prio_idx_o[b*IDX_W +: IDX_W]))); // R2

    AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o[b]) |-> $past(bus_we)); // R3
  end
endmodule

bind irqc_banked irqc_banked_chk #(.NB(NB), .SRC_W(SRC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_i      (src_i),
  .bus_we     (bus_we),
  .irq_o      (irq_o),
  .prio_idx_o (prio_idx_o),
  .prio_vld_o (prio_vld_o)
);

// File: tb/test_irqc_banked.sv
`timescale 1ns/1ps
module test_irqc_banked;
  localparam int NB = 5;
  localparam int SW = 32;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NB*SW-1:0] src;
  logic           bus_we;
  logic [AW-1:0]  bus_addr;
  logic [SW-1:0]  bus_wdata;
  logic [SW-1:0]  bus_rdata;
  logic [NB-1:0]  irq;
  logic [NB*5-1:0] pidx;
  logic [NB-1:0]  pvld;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_raw [NB];
  logic [31:0] m_en  [NB];
  logic [31:0] m_blk [NB];
  logic [31:0] m_prev[NB];

  always #2 clk = ~clk;

  irqc_banked #(.NB(NB), .SRC_W(SW), .ADDR_W(AW)) i_irqc_banked (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq),
    .prio_idx_o(pidx), .prio_vld_o(pvld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit dec(input int a, output int bank, output int off);
    bank = a / 40;
    off  = a % 40;
    return (a < NB * 40) && (off % 8 == 0);
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    int bk, of;
    if (!dec(a, bk, of)) return 32'h0;
    case (of)
      0, 24: return m_raw[bk];
      8:     return m_en[bk];
      16:    return m_raw[bk] & m_en[bk];
      32:    return m_blk[bk];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [4:0] top_bit(input logic [31:0] v);
    logic [4:0] r = 5'd0;
    for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
    return r;
  endfunction

  task automatic check_lines();
    logic [NB-1:0]   e_irq;
    logic [NB*5-1:0] e_idx;
    for (int b = 0; b < NB; b++) begin
      e_irq[b]       = |(m_raw[b] & m_en[b]);
      e_idx[b*5 +: 5] = top_bit(m_raw[b] & m_en[b]);
    end
    chk("R10 line", 32'(irq), 32'(e_irq));
    chk("R10 valid", 32'(pvld), 32'(e_irq));
    chk("R11 index", 32'(pidx), 32'(e_idx));
  endtask

  task automatic step(input logic [NB*SW-1:0] s, input logic we, input int a, input logic [31:0] d);
    logic [31:0] n_raw[NB], n_en[NB], n_blk[NB];
    int bk, of;
    bit ok;
    @(negedge clk);
    src = s; bus_we = we; bus_addr = AW'(a); bus_wdata = d;
    ok = dec(a, bk, of);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] sb, st, cl;
      sb = s[b*SW +: SW];
      st = sb & ~m_prev[b] & ~m_blk[b];
      cl = 32'h0;
      n_en[b] = m_en[b];
      n_blk[b] = m_blk[b];
      if (we && ok && bk == b) begin
        if (of == 24) st = st | d;
        if (of == 0)  cl = d;
        if (of == 8)  n_en[b] = d;
        if (of == 32) n_blk[b] = d;
      end
      n_raw[b] = (m_raw[b] & ~cl) | st;
    end
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      m_raw[b] = n_raw[b]; m_en[b] = n_en[b]; m_blk[b] = n_blk[b];
      m_prev[b] = s[b*SW +: SW];
    end
    #1;
    check_lines();
  endtask

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = AW'(a);
    #1;
    chk(tag, bus_rdata, exp_rd(a));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NB*SW-1:0] s;
    void'($urandom(32'd5150));
    rst_n = 1'b0; src = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int b = 0; b < NB; b++) begin
      m_raw[b] = 0; m_en[b] = 0; m_blk[b] = 0; m_prev[b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 lines", 32'(irq), 32'h0);
    chk("R1 index", 32'(pidx), 32'h0);
    for (int r = 0; r < 5; r++) rd_chk(r * 8, "R1 bank0 reg");
    for (int r = 0; r < 5; r++) rd_chk(160 + r * 8, "R1 bank4 reg");

    s = '0;
    // R5 enable readback, R9 other banks untouched
    step(s, 1, 48, 32'hA5A5_0F0F);
    rd_chk(48, "R5 enable");
    chk("R5 literal", bus_rdata, 32'hA5A5_0F0F);
    rd_chk(8, "R9 bank0 enable untouched");
    // R2 edge sets pending
    s[32 + 3] = 1'b1;
    step(s, 0, 0, 0);
    rd_chk(40, "R2 raw");
    chk("R2 literal", bus_rdata, 32'h8);
    rd_chk(64, "R2 raw at request offset");
    rd_chk(56, "R6 masked");
    chk("R6 literal", bus_rdata, 32'h8);
    // R6 write ignored
    step(s, 1, 56, 32'hFFFF_FFFF);
    rd_chk(56, "R6 after write");
    rd_chk(48, "R6 enable unchanged");
    // R3 clear
    step(s, 1, 40, 32'h0);
    rd_chk(40, "R3 zero write keeps");
    step(s, 1, 40, 32'h8);
    rd_chk(40, "R3 cleared");
    chk("R3 literal", bus_rdata, 32'h0);
    step(s, 0, 0, 0);
    rd_chk(40, "R2 held level no reset");
    // R4 set beats clear
    s[32 + 5] = 1'b1;
    step(s, 1, 40, 32'h20);
    rd_chk(40, "R4 set wins");
    chk("R4 literal", bus_rdata, 32'h20);
    // R7 software request, R11 index 31
    step(s, 1, 104, 32'h8000_0001);
    rd_chk(80, "R7 request set");
    step(s, 1, 88, 32'hFFFF_FFFF);
    chk("R11 bank2 index 31", 32'(pidx[2*5 +: 5]), 32'd31);
    // R8 capture block
    step(s, 1, 32, 32'h1);
    rd_chk(32, "R8 block readback");
    s[0] = 1'b1;
    step(s, 0, 0, 0);
    rd_chk(0, "R8 blocked edge");
    chk("R8 literal", bus_rdata, 32'h0);
    step(s, 1, 24, 32'h1);
    rd_chk(0, "R8 request still sets");
    // R12 unmapped
    step(s, 1, 1, 32'hFFFF_FFFF);
    rd_chk(0, "R12 misaligned write ignored");
    rd_chk(1, "R12 misaligned read");
    step(s, 1, 200, 32'hFFFF_FFFF);
    rd_chk(200, "R12 beyond last bank");
    rd_chk(252, "R12 high address");
    rd_chk(160, "R9 bank4 raw");

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int a;
      for (int b = 0; b < NB; b++)
        s[b*SW +: SW] = s[b*SW +: SW] ^ ($urandom & $urandom & $urandom);
      if ($urandom % 4 != 0) a = ($urandom % NB) * 40 + ($urandom % 5) * 8;
      else a = $urandom % 256;
      step(s, ($urandom % 3) != 0, a, $urandom);
      if ($urandom % 4 != 0) a = ($urandom % NB) * 40 + ($urandom % 5) * 8;
      else a = $urandom % 256;
      rd_chk(a, "R9 R12 random read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule